// File: doc/BRIEF.md
# Clock-Stop SPI Master Port

This block is a serial port that acts as an SPI master and keeps its serial clock stopped between words. Software or a sequencer places a word on `tx_word`, picks a word length and a divider value, and pulses `start`. The port pulls its active-low select low. It then runs a gated clock whose period and duty cycle come from the divider. It shifts the word out most significant bit first while it collects the slave's reply, releases the select, and presents the reply with a one-cycle `done` pulse.

The divider counts input periods of either the core clock or an external clock pin. The external clock is brought into the core domain through a synchronizer, and each of its rising edges counts as one input period. A divider value d gives a serial period of d+1 input periods. With an odd d both halves are equal. With an even d the high half is one period longer than the low half. A value of zero behaves like one, because no phase can be shorter than a single input period. The divider, length and transmit word are captured when `start` is accepted, so they may change freely during a transfer.

Top module: `spi_cs_master`

## Requirements
- R1: With `clk_src_sel`=1 and an even non-zero `div_val` d, every high phase of `sclk` lasts d/2+1 `clk` cycles and every low phase between high phases lasts d/2 cycles.
- R2: With an odd `div_val` d, high and low phases each last (d+1)/2 cycles. A `div_val` of 0 gives 1-cycle high and low phases, the same as 1.
- R3: `ss_n` falls on the clock edge after `start` is accepted. `sclk` first rises one low-phase length later, so the first falling `sclk` edge comes one full serial period after `ss_n` falls.
- R4: After the last high phase ends, `sclk` stays low and `ss_n` stays low for one high-phase length, then `ss_n` returns high.
- R5: The word goes out on `sdo` most significant bit first, one bit per `sclk` period. `sdo` changes only on the edge where `sclk` rises and holds through the high phase. `len_sel` selects the word length: 00 for 8 bits, 01 for 16 bits, 10 or 11 for 32 bits. A word of n bits uses the low n bits of `tx_word` and gives exactly n high phases.
- R6: `sdi` is sampled as `sclk` falls. After the transfer, `rx_word` holds the n received bits right-aligned, the first received bit in position n-1, and all upper bits zero.
- R7: `sdo_oe` is high from the first rising `sclk` edge until the end of the last high phase, and low in the lead-in, in the tail and while `ss_n` is high. `sdo` is high impedance whenever `sdo_oe` is low.
- R8: With `clk_src_sel`=0, the divider counts rising edges of `ext_clk` after a two-stage synchronizer instead of `clk` cycles. With `ext_clk` of period 4 `clk` cycles, each phase lasts 4 times its length in input periods.
- R9: `busy` is high from the accepted `start` until `ss_n` has returned high. A `start` pulse while `busy` is ignored: the word in flight and its length are not changed, and no extra transfer follows.
- R10: `done` is a single-cycle pulse in the cycle where `ss_n` first reads high again and `busy` is low. `rx_word` is valid from that cycle on.
- R11: After reset `ss_n`=1, `sclk`=0, `sdo_oe`=0, `busy`=0 and `done`=0, and `sclk` is never high while `ss_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_src_sel | input | 1 | 1: divider counts `clk` cycles; 0: divider counts `ext_clk` rising edges |
| ext_clk | input | 1 | External divider input clock, asynchronous |
| div_val | input | DIV_W | Divider value d, serial period d+1 input periods |
| len_sel | input | 2 | Word length: 00=8, 01=16, 1x=32 bits |
| start | input | 1 | Start strobe, accepted only when not busy |
| tx_word | input | WMAX | Word to transmit, right-aligned |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at end of transfer |
| rx_word | output | WMAX | Received word, right-aligned |
| sclk | output | 1 | Serial clock, idle low |
| ss_n | output | 1 | Active-low slave select |
| sdo | output | 1 | Serial data out, tri-stated when idle |
| sdo_oe | output | 1 | Output enable of `sdo` |
| sdi | input | 1 | Serial data in |

## Verification
A phase counter that is loaded wrongly or wraps shows at the pins within one serial period, as a high or low run of the wrong length measured in `clk` cycles. A bit counter that is off by one shows by the end of the word, as a wrong number of high phases, a shifted `rx_word`, or a tail that starts early. A state machine that leaves idle on a stray start, or returns there late, shows within one `clk` cycle on `ss_n`, `busy` or `done`. Bit order and sampling edge are checked against an independent slave model in the bench, so a swapped edge corrupts the word the bench compares.

// File: rtl/spi_cs_pkg.sv
// Shared types for the clock-stop SPI master.
// Assumes word lengths of 8, 16 and 32 bits only.
package spi_cs_pkg;

    // Transfer sequencer states: lead-in, clock high, clock low, tail.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_TAIL
    } xfer_st_t;

    // Map the length select code to a bit count: 00=8, 01=16, 1x=32.
    function automatic int word_bits(input logic [1:0] sel);
        case (sel)
            2'b00:   return 8;
            2'b01:   return 16;
            default: return 32;
        endcase
    endfunction

endpackage

// File: rtl/spi_cs_tick.sv
// Divider input selector: produces one tick per input period.
// With src_sel=1 every core cycle is a tick. With src_sel=0 the
// external clock passes through SYNC flops, and each of its rising
// edges yields one tick. The external clock must be slower than clk/2.
module spi_cs_tick #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_sel,
    input  logic ext_clk,
    output logic tick
);
    logic [SYNC-1:0] sync_q;
    logic            prev_q;

    // Synchronize the external clock and keep its last settled value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC-2:0], ext_clk};
            prev_q <= sync_q[SYNC-1];
        end
    end

    assign tick = src_sel ? 1'b1 : (sync_q[SYNC-1] & ~prev_q);
endmodule

// File: rtl/spi_cs_timer.sv
// Phase timer: loaded with (length-1), counts ticks down to zero.
// expire is high on the tick that ends the phase. The owner reloads
// it on expire; it rests at zero otherwise.
module spi_cs_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         expire
);
    logic [W-1:0] cnt;

    // Load on request, otherwise count ticks down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (tick && cnt != '0)
            cnt <= cnt - W'(1);
    end

    assign expire = tick && (cnt == '0);

    // R1: without a load or a tick the count must not move
    tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(cnt));
endmodule

// File: rtl/spi_cs_shifter.sv
// Transmit and receive shift registers. The transmit word is
// left-aligned on load, so its MSB always sits in the top bit. The
// receive register is cleared on load and shifts sdi in at the bottom,
// which leaves an n-bit word right-aligned after n samples.
module spi_cs_shifter #(
    parameter int WMAX = 32,
    localparam int CW = $clog2(WMAX + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [WMAX-1:0] tx_word,
    input  logic [CW-1:0]   nbits,
    input  logic            shift_out,
    input  logic            sample,
    input  logic            sdi,
    output logic            msb,
    output logic [WMAX-1:0] rx_word
);
    logic [WMAX-1:0] tx_sh;
    logic [WMAX-1:0] rx_sh;
    logic [CW-1:0]   sh_amt;

    assign sh_amt = CW'(WMAX) - nbits;

    // Load the aligned word, advance it on each rising serial edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_sh <= '0;
        else if (load)
            tx_sh <= tx_word << sh_amt;
        else if (shift_out)
            tx_sh <= tx_sh << 1;
    end

    // Clear at start, collect one bit per falling serial edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_sh <= '0;
        else if (load)
            rx_sh <= '0;
        else if (sample)
            rx_sh <= {rx_sh[WMAX-2:0], sdi};
    end

    assign msb     = tx_sh[WMAX-1];
    assign rx_word = rx_sh;
endmodule

// File: rtl/spi_cs_master.sv
// Clock-stop SPI master. One start strobe runs one word: select low,
// a lead-in of one low phase, n clock periods (high then low, with no
// low after the last high), a tail of one high phase, then select high
// with a done pulse. Divider, length and data are captured at start.
// All pins come from flops, decoded from the next state.
module spi_cs_master #(
    parameter int DIV_W = 8,
    parameter int WMAX  = 32,
    parameter int SYNC  = 2,
    localparam int CW = $clog2(WMAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_src_sel,
    input  logic             ext_clk,
    input  logic [DIV_W-1:0] div_val,
    input  logic [1:0]       len_sel,
    input  logic             start,
    input  logic [WMAX-1:0]  tx_word,
    output logic             busy,
    output logic             done,
    output logic [WMAX-1:0]  rx_word,
    output logic             sclk,
    output logic             ss_n,
    output logic             sdo,
    output logic             sdo_oe,
    input  logic             sdi
);
    import spi_cs_pkg::*;

    xfer_st_t          st, st_nxt;
    logic              tick, expire;
    logic              tmr_load, sh_load, sh_out, smp, fin;
    logic [DIV_W-1:0]  tmr_val;
    logic [DIV_W-1:0]  hi_len, lo_len, hi_r, lo_r;
    logic [DIV_W:0]    half_up;
    logic [CW-1:0]     nb_r, bit_cnt;
    logic              msb;
    logic [WMAX-1:0]   rx_sh;

    spi_cs_tick #(.SYNC(SYNC)) i_tick (
        .clk(clk), .rst_n(rst_n), .src_sel(clk_src_sel),
        .ext_clk(ext_clk), .tick(tick)
    );

    spi_cs_timer #(.W(DIV_W)) i_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .tick(tick), .expire(expire)
    );

    spi_cs_shifter #(.WMAX(WMAX)) i_shift (
        .clk(clk), .rst_n(rst_n), .load(sh_load), .tx_word(tx_word),
        .nbits(CW'(word_bits(len_sel))), .shift_out(sh_out), .sample(smp),
        .sdi(sdi), .msb(msb), .rx_word(rx_sh)
    );

    // Phase lengths from the divider: odd or zero splits evenly, even adds one to high.
    always_comb begin
        half_up = ({1'b0, div_val} + (DIV_W+1)'(1)) >> 1;
        if (div_val == '0) begin
            hi_len = DIV_W'(1);
            lo_len = DIV_W'(1);
        end else if (div_val[0]) begin
            hi_len = half_up[DIV_W-1:0];
            lo_len = half_up[DIV_W-1:0];
        end else begin
            lo_len = div_val >> 1;
            hi_len = lo_len + DIV_W'(1);
        end
    end

    // Sequencer: next state and the one-cycle controls for timer and shifter.
    always_comb begin
        st_nxt   = st;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_out   = 1'b0;
        smp      = 1'b0;
        fin      = 1'b0;
        case (st)
            ST_IDLE: if (start) begin
                st_nxt   = ST_LEAD;
                tmr_load = 1'b1;
                tmr_val  = lo_len - DIV_W'(1);
                sh_load  = 1'b1;
            end
            ST_LEAD: if (expire) begin
                st_nxt   = ST_HIGH;
                tmr_load = 1'b1;
                tmr_val  = hi_r - DIV_W'(1);
            end
            ST_HIGH: if (expire) begin
                smp      = 1'b1;
                tmr_load = 1'b1;
                if (bit_cnt == nb_r - CW'(1)) begin
                    st_nxt  = ST_TAIL;
                    tmr_val = hi_r - DIV_W'(1);
                end else begin
                    st_nxt  = ST_LOW;
                    tmr_val = lo_r - DIV_W'(1);
                end
            end
            ST_LOW: if (expire) begin
                st_nxt   = ST_HIGH;
                tmr_load = 1'b1;
                tmr_val  = hi_r - DIV_W'(1);
                sh_out   = 1'b1;
            end
            ST_TAIL: if (expire) begin
                st_nxt = ST_IDLE;
                fin    = 1'b1;
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // State, captured settings and bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            hi_r    <= DIV_W'(1);
            lo_r    <= DIV_W'(1);
            nb_r    <= CW'(8);
            bit_cnt <= '0;
        end else begin
            st <= st_nxt;
            if (sh_load) begin
                hi_r    <= hi_len;
                lo_r    <= lo_len;
                nb_r    <= CW'(word_bits(len_sel));
                bit_cnt <= '0;
            end else if (sh_out) begin
                bit_cnt <= bit_cnt + CW'(1);
            end
        end
    end

    // Registered pins decoded from the next state, plus done and the result word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk    <= 1'b0;
            ss_n    <= 1'b1;
            sdo_oe  <= 1'b0;
            done    <= 1'b0;
            rx_word <= '0;
        end else begin
            sclk   <= (st_nxt == ST_HIGH);
            ss_n   <= (st_nxt == ST_IDLE);
            sdo_oe <= (st_nxt == ST_HIGH) || (st_nxt == ST_LOW);
            done   <= fin;
            if (fin)
                rx_word <= rx_sh;
        end
    end

    assign busy = (st != ST_IDLE);
    assign sdo  = sdo_oe ? msb : 1'bz;

    // R7
    oe_framed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> !ss_n);
    // R11
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n |-> !sclk);
    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ss_n && !$past(ss_n) && !busy));
    // R9
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ss_n) |-> ($past(start) && !$past(busy)));
    // R5
    sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdo));
endmodule

// File: tb/test_spi_cs_master.sv
module test_spi_cs_master;
    localparam int CLK_PER = 10;
    localparam int NV = 6;
    // {tx, slave reply, divider, length code}
    localparam logic [73:0] VEC [NV] = '{
        {32'h000000A5, 32'h0000003C, 8'd2, 2'b00},
        {32'h00001234, 32'h0000BEEF, 8'd3, 2'b01},
        {32'hDEADBEEF, 32'h80000001, 8'd0, 2'b10},
        {32'h0000005A, 32'h000000C3, 8'd5, 2'b00},
        {32'h8001F00F, 32'h7FFE0FF0, 8'd4, 2'b11},
        {32'h00000069, 32'h00000096, 8'd1, 2'b00}
    };

    logic clk = 0, rst_n = 0, clk_src_sel = 1, ext_clk = 0;
    logic [7:0] div_val = 0;
    logic [1:0] len_sel = 0;
    logic start = 0;
    logic [31:0] tx_word = 0;
    logic busy, done, sclk, ss_n, sdo, sdo_oe;
    logic [31:0] rx_word;
    logic sdi = 0;

    int total = 0, bad = 0, cyc = 0;

    spi_cs_master i_spi_cs_master (
        .clk(clk), .rst_n(rst_n), .clk_src_sel(clk_src_sel), .ext_clk(ext_clk),
        .div_val(div_val), .len_sel(len_sel), .start(start), .tx_word(tx_word),
        .busy(busy), .done(done), .rx_word(rx_word), .sclk(sclk), .ss_n(ss_n),
        .sdo(sdo), .sdo_oe(sdo_oe), .sdi(sdi)
    );

    always #(CLK_PER/2) clk = ~clk;

    // External divider clock: period of 4 core cycles.
    int ext_div = 0;
    always @(posedge clk) begin
        ext_div <= ext_div + 1;
        if (ext_div % 2 == 1) ext_clk <= ~ext_clk;
    end

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            total++; bad++;
            $display("FAIL watchdog (all) act=%0d exp<100000", cyc);
            summary();
            $finish;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    // Slave model: MSB first, next bit after each falling sclk.
    logic [31:0] slave_word = 0, sreg;
    int exp_n = 8;
    always @(negedge ss_n) begin
        sreg = slave_word << (32 - exp_n);
        sdi  = sreg[31];
    end
    always @(negedge sclk) if (!ss_n) begin
        sreg = sreg << 1;
        sdi  = sreg[31];
    end

    // Pin monitor: measures run lengths in core cycles at the falling clk edge.
    logic prev_ss = 1, prev_sclk = 0;
    int run = 0, hcount = 0, lead = 0, tail = 0;
    int hmin = 0, hmax = 0, lmin = 0, lmax = 0, done_cnt = 0, done_run = 0, done_max = 0;
    logic [31:0] cap = 0, rx_cap = 0;
    logic oe_bad = 0, busy_at_done = 0, ss_at_done = 0;
    always @(negedge clk) if (rst_n) begin
        if (prev_ss && !ss_n) begin
            hcount = 0; lead = 0; tail = 0; cap = 0; oe_bad = 0;
            hmin = 9999; hmax = 0; lmin = 9999; lmax = 0;
        end
        if (ss_n != prev_ss || sclk != prev_sclk) begin
            if (!prev_ss) begin
                if (prev_sclk) begin
                    hcount++;
                    if (run < hmin) hmin = run;
                    if (run > hmax) hmax = run;
                end else if (ss_n) tail = run;
                else if (hcount == 0) lead = run;
                else begin
                    if (run < lmin) lmin = run;
                    if (run > lmax) lmax = run;
                end
            end
            if (sclk && !prev_sclk) cap = {cap[30:0], sdo};
            run = 1;
        end else run++;
        if (ss_n && sdo_oe) oe_bad = 1;
        if (!ss_n && !sclk && (hcount == 0 || hcount == exp_n) && sdo_oe) oe_bad = 1;
        if (!ss_n && !sclk && hcount > 0 && hcount < exp_n && !sdo_oe) oe_bad = 1;
        if (done) begin
            done_cnt++; rx_cap = rx_word; busy_at_done = busy; ss_at_done = ss_n;
            done_run++;
            if (done_run > done_max) done_max = done_run;
        end else done_run = 0;
        prev_ss = ss_n; prev_sclk = sclk;
    end

    function automatic int hi_of(input int d);
        if (d == 0) return 1;
        if (d % 2 == 1) return (d + 1) / 2;
        return d / 2 + 1;
    endfunction
    function automatic int lo_of(input int d);
        if (d == 0) return 1;
        if (d % 2 == 1) return (d + 1) / 2;
        return d / 2;
    endfunction
    function automatic int n_of(input logic [1:0] s);
        return (s == 2'b00) ? 8 : (s == 2'b01) ? 16 : 32;
    endfunction

    task automatic run_xfer(input logic [31:0] tx, input logic [31:0] rep,
                            input int d, input logic [1:0] ls, input logic src);
        int n = n_of(ls);
        int sc = src ? 1 : 4;
        int d0 = done_cnt;
        logic [31:0] m = (n == 32) ? 32'hFFFFFFFF : ((32'h1 << n) - 1);
        exp_n = n; slave_word = rep; clk_src_sel = src;
        @(negedge clk);
        tx_word = tx; div_val = 8'(d); len_sel = ls; start = 1;
        @(negedge clk);
        start = 0; tx_word = ~tx; div_val = 8'd9; len_sel = 2'b00;
        while (done_cnt == d0) @(negedge clk);
        // R5 bit count and MSB-first order
        check("R5", "high phases", hcount, n);
        check("R5", "tx word", cap & m, tx & m);
        // R6 received word right-aligned
        check("R6", "rx word", rx_cap, rep & m);
        // R1/R2 phase widths (R8 scaled for external clock)
        check(d % 2 == 1 || d == 0 ? "R2" : "R1", "high min", hmin, hi_of(d) * sc);
        check(d % 2 == 1 || d == 0 ? "R2" : "R1", "high max", hmax, hi_of(d) * sc);
        check(d % 2 == 1 || d == 0 ? "R2" : "R1", "low min", lmin, lo_of(d) * sc);
        check(d % 2 == 1 || d == 0 ? "R2" : "R1", "low max", lmax, lo_of(d) * sc);
        if (src) check("R3", "lead", lead, lo_of(d));
        // R4 tail before select release
        check("R4", "tail", tail, hi_of(d) * sc);
        // R7 output enable window
        check("R7", "oe window", oe_bad, 0);
        // R10 done at select release
        check("R10", "ss at done", ss_at_done, 1);
        check("R10", "busy at done", busy_at_done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        check("R11", "ss_n", ss_n, 1);
        check("R11", "sclk", sclk, 0);
        check("R11", "sdo_oe", sdo_oe, 0);
        check("R11", "busy", busy, 0);
        check("R11", "done", done, 0);

        for (int i = 0; i < NV; i++)
            run_xfer(VEC[i][73:42], VEC[i][41:10], int'(VEC[i][9:2]), VEC[i][1:0], 1'b1);

        // R8 external clock source, 4 core cycles per input period
        run_xfer(32'h000000C5, 32'h0000003A, 2, 2'b00, 1'b0);
        clk_src_sel = 1;

        // R9 start while busy is ignored
        begin
            int d0;
            exp_n = 8; slave_word = 32'h5E;
            @(negedge clk);
            d0 = done_cnt;
            tx_word = 32'h000000B7; div_val = 8'd1; len_sel = 2'b00; start = 1;
            @(negedge clk); start = 0;
            repeat (6) @(negedge clk);
            check("R9", "busy mid word", busy, 1);
            tx_word = 32'hFFFF0000; len_sel = 2'b10; start = 1;
            @(negedge clk); start = 0;
            while (done_cnt == d0) @(negedge clk);
            check("R9", "tx word kept", cap & 32'hFF, 32'hB7);
            check("R9", "length kept", hcount, 8);
            check("R6", "rx during busy test", rx_cap, 32'h5E);
            repeat (40) @(negedge clk);
            check("R9", "no extra transfer", done_cnt, d0 + 1);
            check("R9", "select idle", ss_n, 1);
            check("R10", "done width", done_max, 1);
        end

        summary();
        $finish;
    end
endmodule